// File: doc/BRIEF.md
# Serial Configuration Engine Register Bank

This block is the processor-facing register bank for a serial engine that configures an attached target chip. Software loads a 40-bit configuration word and a 40-bit configuration address. Each value is split across a low 32-bit register and a high register that holds the top eight bits. The two 40-bit values go straight to the engine. To launch a transfer, software moves a control bit from low to high. The block turns that rising edge into a one-cycle start strobe. The strobe is withheld while the engine reports that it is busy.

The same control register drives an active-low cold reset for the target chip, and a style bit picks one of two behaviours for it:
- **Level mode:** the reset output follows the software-written bit.
- **Retimed mode:** a high-to-low write of the bit produces a short low pulse of fixed length.

When the engine finishes a transfer, the block captures the 20-bit word the engine returns and raises a sticky "result ready" flag. Reading the result register clears the flag. A status register combines that flag with the engine's ready and busy indications.

The bus is a simple word-addressed interface. A write takes effect at the clock edge on which the write enable is high. Read data is combinational from the address. A read strobe is needed only for the clear-on-read side effect.

Top module: `spicfg_regbank`

## Requirements
- R1: Word offset 0 holds configuration bits 31:0 and offset 1 holds bits 39:32 in its bits 7:0; offsets 2 and 3 hold the configuration address the same way. High registers read back with bits 31:8 as zero, and the full 40-bit values appear on `cfg_data_o` and `cfg_addr_o` the cycle after the write.
- R2: Offset 4 is the control register, with bit 0 = start, bit 1 = active-low target reset level and bit 2 = reset style (1 = level, 0 = retimed). It resets to 0x00000006, and bits 31:3 read as zero.
- R3: Offset 5 is a 32-bit read/write scratch register that resets to zero and changes only when offset 5 is written.
- R4: A write that moves control bit 0 from 0 to 1 makes `start_o` high for exactly one cycle, the cycle after the write. The strobe is suppressed if `eng_busy_i` is high in that cycle.
- R5: In retimed style, a write that moves control bit 1 from 1 to 0 drives `tgt_rst_n_o` low for exactly PULSE_CYC cycles, starting two cycles after the write edge.
- R6: In level style, `tgt_rst_n_o` equals control bit 1 from the cycle after the write.
- R7: Offset 6 is read-only status, with bit 0 = result ready, bit 1 = `eng_ready_i` and bit 2 = `eng_busy_i`, and bits 31:3 as zero.
- R8: An `eng_done_i` cycle captures `eng_miso_i` and sets result ready. A read of offset 7 (`bus_rd` high) clears result ready. A done in the same cycle as that read leaves result ready set.
- R9: Offset 7 returns the captured 20-bit word zero-extended to 32 bits, and the word changes only on `eng_done_i`.
- R10: Writes to offsets 6 and 7 have no effect. Offsets from 8 up to 2^ADDR_W-1 read as zero, and writes to them change no register.
- R11: After reset, all data, address, scratch and result registers are zero, result ready is clear, `start_o` is low and `tgt_rst_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe (side effect on offset 7 only) |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| cfg_data_o | output | 40 | Configuration word to engine |
| cfg_addr_o | output | 40 | Configuration address to engine |
| start_o | output | 1 | One-cycle transfer start strobe |
| tgt_rst_n_o | output | 1 | Active-low target cold reset |
| eng_ready_i | input | 1 | Engine can take a new transfer |
| eng_busy_i | input | 1 | Engine transfer in progress |
| eng_done_i | input | 1 | Engine finished; result valid this cycle |
| eng_miso_i | input | 20 | Result word returned by the engine |

## Verification
The bench builds the block with PULSE_CYC = 3 and ADDR_W = 4. The three-cycle retimed pulse makes a miscounted or off-by-one pulse length visible, where the one-cycle default would hide it. The extra address bit puts offsets 8 to 15 on the bus, so the bench can check both zero readback and ignored writes for unmapped words. A behavioural model updated on every clock is compared against all outputs each cycle. The run covers the busy-gated start strobe and a result-ready flag that is set and cleared in the same cycle.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

    localparam int WORD_W = 32;
    localparam int CFG_W  = 40;
    localparam int HI_W   = CFG_W - WORD_W;
    localparam int MISO_W = 20;
    localparam int MAP_W  = 3;

    localparam logic [MAP_W-1:0] OFF_DATA_LO = 3'd0;
    localparam logic [MAP_W-1:0] OFF_DATA_HI = 3'd1;
    localparam logic [MAP_W-1:0] OFF_ADDR_LO = 3'd2;
    localparam logic [MAP_W-1:0] OFF_ADDR_HI = 3'd3;
    localparam logic [MAP_W-1:0] OFF_CTRL    = 3'd4;
    localparam logic [MAP_W-1:0] OFF_SCRATCH = 3'd5;
    localparam logic [MAP_W-1:0] OFF_STATUS  = 3'd6;
    localparam logic [MAP_W-1:0] OFF_RESULT  = 3'd7;

    typedef struct packed {
        logic style_level;
        logic cold_rst_n;
        logic go;
    } ctrl_t;

    typedef struct packed {
        logic busy;
        logic eng_ready;
        logic result_rdy;
    } status_t;

    localparam ctrl_t CTRL_INIT = '{style_level: 1'b1, cold_rst_n: 1'b1, go: 1'b0};

    function automatic logic [WORD_W-1:0] pad_word(input logic [HI_W-1:0] v);
        return {{(WORD_W-HI_W){1'b0}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] pad_ctrl(input ctrl_t c);
        return {{(WORD_W-3){1'b0}}, c};
    endfunction

    function automatic logic [WORD_W-1:0] pad_status(input status_t s);
        return {{(WORD_W-3){1'b0}}, s};
    endfunction

    function automatic logic [WORD_W-1:0] pad_result(input logic [MISO_W-1:0] v);
        return {{(WORD_W-MISO_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/spicfg_edge_det.sv
module spicfg_edge_det #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= INIT;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/spicfg_cfg_regs.sv
module spicfg_cfg_regs
    import spicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [MAP_W-1:0]  off_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CFG_W-1:0]  data_o,
    output logic [CFG_W-1:0]  addr_o,
    output logic [WORD_W-1:0] scratch_o,
    output ctrl_t             ctrl_o
);
    localparam int NWIDE = 2;
    localparam logic [MAP_W-1:0] LO_OFF [NWIDE] = '{OFF_DATA_LO, OFF_ADDR_LO};
    localparam logic [MAP_W-1:0] HI_OFF [NWIDE] = '{OFF_DATA_HI, OFF_ADDR_HI};

    logic [CFG_W-1:0] wide_q [NWIDE];

    for (genvar g = 0; g < NWIDE; g++) begin : g_wide
        always_ff @(posedge clk) begin
            if (rst) begin
                wide_q[g] <= '0;
            end else if (wr_i && off_i == LO_OFF[g]) begin
                wide_q[g][WORD_W-1:0] <= wdata_i;
            end else if (wr_i && off_i == HI_OFF[g]) begin
                wide_q[g][CFG_W-1:WORD_W] <= wdata_i[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_o <= '0;
            ctrl_o    <= CTRL_INIT;
        end else if (wr_i) begin
            if (off_i == OFF_SCRATCH) scratch_o <= wdata_i;
            if (off_i == OFF_CTRL)    ctrl_o    <= ctrl_t'(wdata_i[2:0]);
        end
    end

    assign data_o = wide_q[0];
    assign addr_o = wide_q[1];

    assert_scratch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && off_i == OFF_SCRATCH) |=> $stable(scratch_o));

endmodule

// File: rtl/spicfg_tgt_reset.sv
module spicfg_tgt_reset #(
    parameter int PULSE_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic level_mode_i,
    input  logic lvl_i,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    logic             fall;
    logic             rise_unused;
    logic [CNT_W-1:0] cnt_q;

    spicfg_edge_det #(.INIT(1'b1)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_i),
        .rise_o (rise_unused),
        .fall_o (fall)
    );

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (!level_mode_i && fall) cnt_q <= CNT_W'(PULSE_CYC);
        else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
    end

    assign rst_n_o = level_mode_i ? lvl_i : (cnt_q == '0);

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (!level_mode_i && $fell(rst_n_o)) |-> $past(fall && !level_mode_i));

    assert_pulse_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(PULSE_CYC));

endmodule

// File: rtl/spicfg_miso_capture.sv
module spicfg_miso_capture
    import spicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [MISO_W-1:0] miso_i,
    input  logic              rd_clear_i,
    output logic [MISO_W-1:0] word_o,
    output logic              rdy_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            rdy_o  <= 1'b0;
        end else begin
            if (done_i) word_o <= miso_i;
            if (done_i)          rdy_o <= 1'b1;
            else if (rd_clear_i) rdy_o <= 1'b0;
        end
    end

    assert_done_sets_rdy_R8: assert property (@(posedge clk) disable iff (rst)
        done_i |=> rdy_o);

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(word_o));

endmodule

// File: rtl/spicfg_regbank.sv
module spicfg_regbank
    import spicfg_pkg::*;
#(
    parameter int PULSE_CYC = 1,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CFG_W-1:0]  cfg_data_o,
    output logic [CFG_W-1:0]  cfg_addr_o,
    output logic              start_o,
    output logic              tgt_rst_n_o,
    input  logic              eng_ready_i,
    input  logic              eng_busy_i,
    input  logic              eng_done_i,
    input  logic [MISO_W-1:0] eng_miso_i
);
    logic              mapped;
    logic [MAP_W-1:0]  off;
    logic [WORD_W-1:0] scratch;
    ctrl_t             ctrl;
    status_t           status;
    logic [MISO_W-1:0] result;
    logic              result_rdy;
    logic              go_rise;
    logic              go_fall_unused;

    if (ADDR_W > MAP_W) begin : g_wide_addr
        assign mapped = (bus_addr[ADDR_W-1:MAP_W] == '0);
    end else begin : g_exact_addr
        assign mapped = 1'b1;
    end
    assign off = bus_addr[MAP_W-1:0];

    spicfg_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (bus_wr && mapped),
        .off_i     (off),
        .wdata_i   (bus_wdata),
        .data_o    (cfg_data_o),
        .addr_o    (cfg_addr_o),
        .scratch_o (scratch),
        .ctrl_o    (ctrl)
    );

    spicfg_edge_det #(.INIT(1'b0)) u_go_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (ctrl.go),
        .rise_o (go_rise),
        .fall_o (go_fall_unused)
    );

    assign start_o = go_rise && !eng_busy_i;

    spicfg_tgt_reset #(.PULSE_CYC(PULSE_CYC)) u_rst (
        .clk          (clk),
        .rst          (rst),
        .level_mode_i (ctrl.style_level),
        .lvl_i        (ctrl.cold_rst_n),
        .rst_n_o      (tgt_rst_n_o)
    );

    spicfg_miso_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .done_i     (eng_done_i),
        .miso_i     (eng_miso_i),
        .rd_clear_i (bus_rd && mapped && off == OFF_RESULT),
        .word_o     (result),
        .rdy_o      (result_rdy)
    );

    assign status = '{busy: eng_busy_i, eng_ready: eng_ready_i, result_rdy: result_rdy};

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            case (off)
                OFF_DATA_LO: bus_rdata = cfg_data_o[WORD_W-1:0];
                OFF_DATA_HI: bus_rdata = pad_word(cfg_data_o[CFG_W-1:WORD_W]);
                OFF_ADDR_LO: bus_rdata = cfg_addr_o[WORD_W-1:0];
                OFF_ADDR_HI: bus_rdata = pad_word(cfg_addr_o[CFG_W-1:WORD_W]);
                OFF_CTRL:    bus_rdata = pad_ctrl(ctrl);
                OFF_SCRATCH: bus_rdata = scratch;
                OFF_STATUS:  bus_rdata = pad_status(status);
                default:     bus_rdata = pad_result(result);
            endcase
        end
    end

    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    assert_start_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !eng_busy_i);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == '0);

endmodule

// File: tb/tb_spicfg_regbank.sv
module tb_spicfg_regbank;
    localparam int PC = 3;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [39:0] cfg_data_o, cfg_addr_o;
    logic        start_o, tgt_rst_n_o;
    logic        eng_ready_i = 1'b0, eng_busy_i = 1'b0, eng_done_i = 1'b0;
    logic [19:0] eng_miso_i = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spicfg_regbank #(.PULSE_CYC(PC), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_data_o(cfg_data_o), .cfg_addr_o(cfg_addr_o),
        .start_o(start_o), .tgt_rst_n_o(tgt_rst_n_o),
        .eng_ready_i(eng_ready_i), .eng_busy_i(eng_busy_i),
        .eng_done_i(eng_done_i), .eng_miso_i(eng_miso_i)
    );

    // Behavioural reference model
    logic [39:0] m_data, m_addr;
    logic [31:0] m_scr;
    bit   [2:0]  m_ctrl;
    bit          m_go_prev, m_rst_prev;
    int          m_low_left;
    logic [19:0] m_word;
    bit          m_rdy;

    always @(posedge clk) begin
        if (rst) begin
            m_data = '0; m_addr = '0; m_scr = '0; m_ctrl = 3'b110;
            m_go_prev = 0; m_rst_prev = 1; m_low_left = 0;
            m_word = '0; m_rdy = 0;
        end else begin
            if (m_ctrl[2] == 0 && m_rst_prev && !m_ctrl[1]) m_low_left = PC;
            else if (m_low_left > 0) m_low_left--;
            m_go_prev  = m_ctrl[0];
            m_rst_prev = m_ctrl[1];
            if (bus_wr && bus_addr < 8) begin
                case (int'(bus_addr))
                    0: m_data[31:0]  = bus_wdata;
                    1: m_data[39:32] = bus_wdata[7:0];
                    2: m_addr[31:0]  = bus_wdata;
                    3: m_addr[39:32] = bus_wdata[7:0];
                    4: m_ctrl        = bus_wdata[2:0];
                    5: m_scr         = bus_wdata;
                    default: ;
                endcase
            end
            if (eng_done_i) begin m_word = eng_miso_i; m_rdy = 1; end
            else if (bus_rd && bus_addr == 7) m_rdy = 0;
        end
    end

    function automatic logic [31:0] exp_rd(input int a);
        case (a)
            0: return m_data[31:0];
            1: return {24'b0, m_data[39:32]};
            2: return m_addr[31:0];
            3: return {24'b0, m_addr[39:32]};
            4: return {29'b0, m_ctrl};
            5: return m_scr;
            6: return {29'b0, eng_busy_i, eng_ready_i, m_rdy};
            7: return {12'b0, m_word};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(bus_rdata === exp_rd(int'(bus_addr)), "R1/R7/R9/R10 readback", 64'(bus_rdata), 64'(exp_rd(int'(bus_addr))));
            check(cfg_data_o === m_data && cfg_addr_o === m_addr, "R1 cfg outputs", 64'(cfg_data_o), 64'(m_data));
            check(start_o === (m_ctrl[0] && !m_go_prev && !eng_busy_i), "R4 start strobe", 64'(start_o), 64'(m_ctrl[0] && !m_go_prev && !eng_busy_i));
            check(tgt_rst_n_o === (m_ctrl[2] ? m_ctrl[1] : (m_low_left == 0)), "R5/R6 target reset", 64'(tgt_rst_n_o), 64'(m_ctrl[2] ? m_ctrl[1] : (m_low_left == 0)));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic peek(input int a, input logic [31:0] e, input string req);
        bus_addr = AW'(a);
        #2;
        check(bus_rdata === e, req, 64'(bus_rdata), 64'(e));
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst = 0;
        // R11 reset state, R2 control reset value
        peek(0, 32'h0, "R11 data lo reset");
        peek(5, 32'h0, "R11 scratch reset");
        peek(7, 32'h0, "R11 result reset");
        peek(4, 32'h6, "R2 control reset 0x6");
        check(tgt_rst_n_o === 1'b1 && start_o === 1'b0, "R11 outputs after reset", 64'({tgt_rst_n_o, start_o}), 64'h2);

        // R1 split registers
        wr(0, 32'hDEADBEEF); wr(1, 32'hFFFFFFA5);
        wr(2, 32'h12345678); wr(3, 32'h0000003C);
        peek(1, 32'h000000A5, "R1 data hi zero-extended");
        check(cfg_data_o === 40'hA5DEADBEEF, "R1 cfg_data_o", 64'(cfg_data_o), 64'hA5DEADBEEF);
        check(cfg_addr_o === 40'h3C12345678, "R1 cfg_addr_o", 64'(cfg_addr_o), 64'h3C12345678);

        // R3 scratch, R2 control upper bits
        wr(5, 32'hCAFE0123);
        peek(5, 32'hCAFE0123, "R3 scratch write");
        wr(4, 32'hFFFFFFF6);
        peek(4, 32'h6, "R2 control upper bits zero");

        // R10 read-only and unmapped
        wr(6, 32'hFFFFFFFF); wr(7, 32'hFFFFFFFF);
        peek(7, 32'h0, "R10 result write ignored");
        wr(13, 32'h55555555);
        peek(13, 32'h0, "R10 unmapped reads zero");
        peek(5, 32'hCAFE0123, "R10 unmapped write no effect");

        // R4 start strobe
        eng_ready_i = 1;
        wr(4, 32'h7);
        n = 0;
        for (int i = 0; i < 4; i++) begin n += start_o; tick(); end
        check(n == 1, "R4 single start pulse", 64'(n), 64'd1);
        wr(4, 32'h6);
        eng_busy_i = 1;
        wr(4, 32'h7);
        n = 0;
        for (int i = 0; i < 4; i++) begin n += start_o; tick(); end
        check(n == 0, "R4 start suppressed while busy", 64'(n), 64'd0);
        peek(6, 32'h6, "R7 status ready+busy");
        eng_busy_i = 0;

        // R6 level style
        wr(4, 32'h4);
        check(tgt_rst_n_o === 1'b0, "R6 level low", 64'(tgt_rst_n_o), 64'd0);
        wr(4, 32'h6);
        check(tgt_rst_n_o === 1'b1, "R6 level high", 64'(tgt_rst_n_o), 64'd1);

        // R5 retimed pulse
        wr(4, 32'h2);
        wr(4, 32'h0);
        check(tgt_rst_n_o === 1'b1, "R5 not yet low one cycle after write", 64'(tgt_rst_n_o), 64'd1);
        n = 0;
        for (int i = 0; i < 8; i++) begin tick(); n += !tgt_rst_n_o; end
        check(n == PC, "R5 pulse width", 64'(n), 64'(PC));

        // R8 / R9 result capture
        eng_miso_i = 20'hABCDE; eng_done_i = 1; tick(); eng_done_i = 0;
        peek(6, 32'h3, "R8 ready set");
        peek(7, 32'h000ABCDE, "R9 result zero-extended");
        bus_rd = 1; bus_addr = 7; tick(); bus_rd = 0;
        peek(6, 32'h2, "R8 cleared by read");
        eng_miso_i = 20'h13579; eng_done_i = 1; bus_rd = 1; bus_addr = 7;
        tick(); eng_done_i = 0; bus_rd = 0;
        peek(6, 32'h3, "R8 done wins over read clear");
        peek(7, 32'h00013579, "R9 new word");
        eng_miso_i = 20'hFFFFF;
        tick();
        peek(7, 32'h00013579, "R9 word held without done");

        repeat (3) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule